// File: doc/BRIEF.md
# Protected Paged Nonvolatile Memory Write Controller

This block is a clock-synchronous model of the control logic inside a parallel, byte-wide, paged nonvolatile memory. A host drives three active-low strobes (select, read enable, write strobe) together with an address and a data byte. Reads behave like a static RAM. Writes are protected: a fixed three-write unlock sequence must come before every programming operation. After the unlock, the host loads bytes of one page into a page buffer in any order. Loading ends when no new byte arrives within a byte-load window. An internal programming period then copies the loaded bytes into the backing array.

While programming is under way, any read returns a status byte instead of array data. Bit 7 is the complement of bit 7 of the most recently written byte. Bit 6 flips on every read. The host polls either bit to find the end of the busy period. A write made without the unlock still starts the busy period, but it stores nothing. The load window and the programming time are clock-cycle counts. The backing array is a small register file that holds a few pages. Higher page numbers alias onto it through the low page-number bits.

Top module: `pgmem_wctl`

## Requirements
- R1: Read enable is active (`dout_en`=1) exactly when `sel_n`=0, `rd_en_n`=0 and `wstb_n`=1. When read enable is inactive, `dout` is 0. When idle, a read returns the array byte at index `addr[PAGE_W+ARR_PG_W-1:0]`. After reset every array byte is 8'hFF.
- R2: A write strobe made while `rd_en_n`=0 has no effect. It does not advance the unlock sequence and does not start the busy period.
- R3: The address of a write is the one present in the first cycle of the strobe (`sel_n`=0, `wstb_n`=0, `rd_en_n`=1). The data of a write is the one present in the last cycle of the strobe. The write takes effect in the cycle after the strobe ends.
- R4: Programming starts only after three writes in a row: 8'hAA to 17'h05555, then 8'h55 to 17'h02AAA, then 8'hA0 to 17'h05555. Command data is never stored. The command addresses can still be programmed as normal data in a later load.
- R5: A write in the idle state that does not continue the unlock sequence (including a broken sequence) starts a busy period of PROG_CYC cycles. That write changes no array byte.
- R6: Only the bytes loaded in one load are programmed, and the rest of the page is untouched. Bytes may come in any order. A byte written twice keeps its last value.
- R7: The page is `addr[ADDR_W-1:PAGE_W]` and the byte within it is `addr[PAGE_W-1:0]`. The first loaded byte fixes the page. A later byte with different page bits is dropped and does not restart the load window.
- R8: Exactly LOAD_CYC cycles after the last accepted byte (or after the unlock if no byte came), the block enters the busy period. A byte accepted before that point restarts the window.
- R9: The busy period lasts PROG_CYC cycles. On the next read after it ends, the block returns the newly programmed data.
- R10: During the busy period, a read returns bit 7 equal to the inverse of bit 7 of the most recent write, and bits 5..0 equal to 0.
- R11: During the busy period, bit 6 of the read data changes value on each new read.
- R12: Writes made during the busy period are ignored. They alter neither the array nor the status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Active-low device select |
| rd_en_n | input | 1 | Active-low output enable |
| wstb_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Byte address (page bits above PAGE_W) |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or busy status, 0 when not reading |
| dout_en | output | 1 | High while a read is active |

## Verification
The bench builds the block with PAGE_W=3 and ARR_PG_W=2, so pages are 8 bytes and the array holds 32 bytes. With these values the bench can program every page completely and read back the whole array after each phase against an arithmetic mirror. LOAD_CYC=20 and PROG_CYC=30 keep the window short enough to probe both sides of each boundary cycle: the last loading cycle against the first busy cycle, and the last busy cycle against the first cycle with valid data. The 17-bit address keeps the real unlock addresses, and their aliases land inside the small array, so the bench can also check that command data is never stored.

// File: rtl/pgmem_pkg.sv
package pgmem_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} pg_state_t;

  localparam logic [16:0] UNL_ADDR_A = 17'h05555;
  localparam logic [16:0] UNL_ADDR_B = 17'h02AAA;
  localparam logic [7:0]  UNL_DAT_1  = 8'hAA;
  localparam logic [7:0]  UNL_DAT_2  = 8'h55;
  localparam logic [7:0]  UNL_DAT_3  = 8'hA0;
endpackage

// File: rtl/pgmem_strobe.sv
module pgmem_strobe #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_en_n,
  input  logic              wstb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              wr_ev,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_act,
  output logic              rd_start
);
  logic              wr_act;
  logic              wr_q, rd_q;
  logic [ADDR_W-1:0] a_q;
  logic [7:0]        d_q;

  assign wr_act   = ~sel_n & ~wstb_n & rd_en_n;
  assign rd_act   = ~sel_n & ~rd_en_n & wstb_n;
  assign rd_start = rd_act & ~rd_q;
  assign wr_ev    = wr_q & ~wr_act;
  assign wr_addr  = a_q;
  assign wr_data  = d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      a_q  <= '0;
      d_q  <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act && !wr_q) a_q <= addr;
      if (wr_act)          d_q <= din;
    end
  end

  AST_EV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_ev |=> !wr_ev) else $error("write event longer than one cycle"); // R3
endmodule

// File: rtl/pgmem_unlock.sv
module pgmem_unlock
  import pgmem_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              done,
  output logic              miss
);
  logic [1:0] stage_q, stage_d;
  logic       match;

  always_comb begin
    unique case (stage_q)
      2'd0:    match = (addr == ADDR_W'(UNL_ADDR_A)) && (data == UNL_DAT_1);
      2'd1:    match = (addr == ADDR_W'(UNL_ADDR_B)) && (data == UNL_DAT_2);
      2'd2:    match = (addr == ADDR_W'(UNL_ADDR_A)) && (data == UNL_DAT_3);
      default: match = 1'b0;
    endcase
    stage_d = stage_q;
    if (ev && en) begin
      if (match && stage_q != 2'd2) stage_d = stage_q + 2'd1;
      else                          stage_d = 2'd0;
    end
  end

  assign done = ev & en & match & (stage_q == 2'd2);
  assign miss = ev & en & ~match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'd0;
    else        stage_q <= stage_d;
  end

  AST_MISS_RESTART: assert property (@(posedge clk) disable iff (!rst_n) miss |=> (stage_q == 2'd0)) else $error("sequence not restarted"); // R4
endmodule

// File: rtl/pgmem_pagebuf.sv
module pgmem_pagebuf #(
  parameter int PAGE_W = 7,
  localparam int NB    = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [PAGE_W-1:0] idx,
  input  logic [7:0]        data,
  output logic [NB*8-1:0]   bytes,
  output logic [NB-1:0]     vld
);
  logic [NB*8-1:0] bytes_q;
  logic [NB-1:0]   vld_q;

  assign bytes = bytes_q;
  assign vld   = vld_q;

  for (genvar i = 0; i < NB; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i]         <= 1'b0;
        bytes_q[i*8 +: 8] <= 8'h00;
      end else if (clr) begin
        vld_q[i]         <= 1'b0;
      end else if (wr && idx == PAGE_W'(i)) begin
        vld_q[i]         <= 1'b1;
        bytes_q[i*8 +: 8] <= data;
      end
    end
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (vld_q == '0)) else $error("buffer not emptied"); // R6
endmodule

// File: rtl/pgmem_wctl.sv
module pgmem_wctl
  import pgmem_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int PAGE_W   = 7,
  parameter int ARR_PG_W = 2,
  parameter int LOAD_CYC = 600,
  parameter int PROG_CYC = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_en_n,
  input  logic              wstb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int NB    = 1 << PAGE_W;
  localparam int IW    = PAGE_W + ARR_PG_W;
  localparam int DEPTH = 1 << IW;
  localparam int PGW   = ADDR_W - PAGE_W;
  localparam int CMAX  = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
  localparam int CW    = $clog2(CMAX + 1);

  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic              wr_ev, rd_act, rd_start;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              ul_done, ul_miss;
  logic [NB*8-1:0]   buf_bytes;
  logic [NB-1:0]     buf_vld;

  pg_state_t   st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [PGW-1:0] page_q, page_d;
  logic           have_pg_q, have_pg_d;
  logic [7:0]     last_d_q, last_d_d;
  logic           tgl_q;
  logic           pg_hit, buf_wr, load_end, prog_end;
  logic [7:0]     mem [DEPTH];
  logic [DEPTH-1:0] wen;

  pgmem_strobe #(.ADDR_W(ADDR_W)) u_stb (
    .clk(clk), .rst_n(rst_s), .sel_n(sel_n), .rd_en_n(rd_en_n), .wstb_n(wstb_n),
    .addr(addr), .din(din), .wr_ev(wr_ev), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_act(rd_act), .rd_start(rd_start)
  );

  pgmem_unlock #(.ADDR_W(ADDR_W)) u_unl (
    .clk(clk), .rst_n(rst_s), .ev(wr_ev), .en(st_q == ST_IDLE),
    .addr(wr_addr), .data(wr_data), .done(ul_done), .miss(ul_miss)
  );

  pgmem_pagebuf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_s), .clr(prog_end), .wr(buf_wr),
    .idx(wr_addr[PAGE_W-1:0]), .data(wr_data), .bytes(buf_bytes), .vld(buf_vld)
  );

  assign pg_hit   = !have_pg_q || (wr_addr[ADDR_W-1:PAGE_W] == page_q);
  assign buf_wr   = (st_q == ST_LOAD) && wr_ev && pg_hit;
  assign load_end = (st_q == ST_LOAD) && (cnt_q == CW'(LOAD_CYC - 1));
  assign prog_end = (st_q == ST_PROG) && (cnt_q == CW'(PROG_CYC - 1));

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    page_d    = page_q;
    have_pg_d = have_pg_q;
    last_d_d  = last_d_q;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (wr_ev) last_d_d = wr_data;
        if (ul_done) begin
          st_d      = ST_LOAD;
          have_pg_d = 1'b0;
        end else if (ul_miss) begin
          st_d = ST_PROG;
        end
      end
      ST_LOAD: begin
        if (buf_wr) begin
          cnt_d     = '0;
          have_pg_d = 1'b1;
          page_d    = wr_addr[ADDR_W-1:PAGE_W];
          last_d_d  = wr_data;
        end else if (load_end) begin
          cnt_d = '0;
          st_d  = ST_PROG;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_PROG: begin
        if (prog_end) begin
          cnt_d = '0;
          st_d  = ST_IDLE;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      page_q    <= '0;
      have_pg_q <= 1'b0;
      last_d_q  <= 8'h00;
      tgl_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      page_q    <= page_d;
      have_pg_q <= have_pg_d;
      last_d_q  <= last_d_d;
      if (rd_start && st_q == ST_PROG) tgl_q <= ~tgl_q;
    end
  end

  for (genvar r = 0; r < DEPTH; r++) begin : g_wen
    assign wen[r] = prog_end && buf_vld[r % NB] &&
                    (page_q[ARR_PG_W-1:0] == ARR_PG_W'(r / NB));
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      for (int r = 0; r < DEPTH; r++) mem[r] <= 8'hFF;
    end else begin
      for (int r = 0; r < DEPTH; r++)
        if (wen[r]) mem[r] <= buf_bytes[(r % NB)*8 +: 8];
    end
  end

  always_comb begin
    if (!rd_act)               dout = 8'h00;
    else if (st_q == ST_PROG)  dout = {~last_d_q[7], tgl_q, 6'b000000};
    else                       dout = mem[addr[IW-1:0]];
  end
  assign dout_en = rd_act;

  AST_LOAD_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_s) (st_q == ST_LOAD && $past(st_q) != ST_LOAD) |-> ($past(st_q) == ST_IDLE)) else $error("load entered without unlock"); // R4
  AST_BUSY_B7_INV: assert property (@(posedge clk) disable iff (!rst_s) (st_q == ST_PROG && dout_en) |-> (dout[7] == ~last_d_q[7])) else $error("status bit 7 wrong"); // R10
  AST_BUSY_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_s) (st_q == ST_PROG && !prog_end) |=> $stable(buf_vld)) else $error("buffer changed while busy"); // R12
  AST_LOAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_s) (st_q == ST_LOAD) |-> (cnt_q < CW'(LOAD_CYC))) else $error("load window overrun"); // R8
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_s) (st_q == ST_LOAD && have_pg_q) |=> $stable(page_q)) else $error("page changed in load"); // R7
endmodule

// File: tb/pgmem_wctl_test.sv
module pgmem_wctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int PW = 3;
  localparam int APW = 2;
  localparam int LC = 20;
  localparam int PC = 30;
  localparam int DEP = 1 << (PW + APW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, rd_en_n = 1'b1, wstb_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  logic [7:0] expm [DEP];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pgmem_wctl #(.ADDR_W(AW), .PAGE_W(PW), .ARR_PG_W(APW), .LOAD_CYC(LC), .PROG_CYC(PC)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_en_n(rd_en_n), .wstb_n(wstb_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr2(input logic [AW-1:0] a1, input logic [7:0] d1,
                     input logic [AW-1:0] a2, input logic [7:0] d2,
                     input logic oe_low, output int p0);
    addr = a1; din = d1; sel_n = 1'b0; wstb_n = 1'b0; rd_en_n = oe_low ? 1'b0 : 1'b1;
    @(negedge clk);
    addr = a2; din = d2;
    @(negedge clk);
    sel_n = 1'b1; wstb_n = 1'b1; rd_en_n = 1'b1;
    @(negedge clk);
    p0 = cyc;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, output int p0);
    wr2(a, d, a, d, 1'b0, p0);
  endtask

  task automatic rd_at(input logic [AW-1:0] a, input int t, output logic [7:0] v);
    while (cyc < t - 1) @(negedge clk);
    addr = a; sel_n = 1'b0; rd_en_n = 1'b0;
    @(negedge clk);
    v = dout;
    sel_n = 1'b1; rd_en_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic unlock(input logic oe_low);
    int p;
    wr2(17'h05555, 8'hAA, 17'h05555, 8'hAA, oe_low, p);
    wr2(17'h02AAA, 8'h55, 17'h02AAA, 8'h55, oe_low, p);
    wr2(17'h05555, 8'hA0, 17'h05555, 8'hA0, oe_low, p);
  endtask

  task automatic sweep(input string req, input logic [AW-1:0] alias_hi);
    logic [7:0] v;
    for (int i = 0; i < DEP; i++) begin
      rd_at(alias_hi | AW'(i), 0, v);
      chk(req, v, expm[i]);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int p, p2;
    logic [7:0] v, prev;
    for (int i = 0; i < DEP; i++) expm[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle outputs, erased array, aliasing
    chk("R1 idle en", {7'b0, dout_en}, 8'h00);
    chk("R1 idle dout", dout, 8'h00);
    sweep("R1 erased", '0);

    // R6: program every page fully, bytes in reverse order
    for (int pg = 0; pg < 4; pg++) begin
      unlock(1'b0);
      for (int i = 7; i >= 0; i--) begin
        logic [7:0] d;
        d = 8'(((pg * 8 + i) * 29 + 7));
        wr(AW'(pg * 8 + i), d, p);
        expm[pg * 8 + i] = d;
      end
      wait_to(p + LC + PC);
    end
    sweep("R6 full pages", '0);
    sweep("R1 alias", 17'h10000);

    // R8 R9 R10 R11 R12: window extension, busy timing, status
    unlock(1'b0);
    wr(17'd9, 8'h3C, p);
    wait_to(p + LC - 4);
    wr(17'd12, 8'hC5, p2);
    rd_at(17'd12, p2 + LC - 1, v);
    chk("R8 still loading", v, expm[12]);
    rd_at(17'd12, p2 + LC, v);
    chk("R8 busy at window end", v & 8'hBF, 8'h00);
    chk("R10 status", v & 8'hBF, {~8'hC5 & 8'h80});
    prev = v;
    for (int k = 0; k < 3; k++) begin
      rd_at(17'd3, 0, v);
      chk("R11 toggle", {7'b0, v[6]}, {7'b0, ~prev[6]});
      prev = v;
    end
    wr(17'd10, 8'h11, p);
    rd_at(17'd9, p2 + LC + PC - 1, v);
    chk("R9 busy last cycle", v & 8'hBF, 8'h00);
    chk("R12 status bit7 kept", {7'b0, v[7]}, 8'h00);
    rd_at(17'd9, p2 + LC + PC, v);
    expm[9] = 8'h3C; expm[12] = 8'hC5;
    chk("R9 data valid", v, 8'h3C);
    rd_at(17'd12, 0, v); chk("R9 second byte", v, 8'hC5);
    rd_at(17'd10, 0, v); chk("R12 ignored write", v, expm[10]);

    // R6 R7 R3: order, overwrite, page mismatch, two-phase strobe
    unlock(1'b0);
    wr(17'd19, 8'h61, p);
    wr(17'd16, 8'h62, p);
    wr(17'd25, 8'h77, p);
    wr(17'd19, 8'h63, p);
    wr2(17'd21, 8'h12, 17'd22, 8'h34, 1'b0, p);
    expm[19] = 8'h63; expm[16] = 8'h62; expm[21] = 8'h34;
    wait_to(p + LC + PC);
    rd_at(17'd25, 0, v); chk("R7 foreign page dropped", v, expm[25]);
    rd_at(17'd21, 0, v); chk("R3 addr first data last", v, 8'h34);
    rd_at(17'd22, 0, v); chk("R3 second addr unused", v, expm[22]);
    sweep("R6 partial page", '0);

    // R4: empty load after unlock stores nothing; command address usable
    unlock(1'b0);
    p = cyc;
    wait_to(p + LC + PC + 2);
    sweep("R4 commands not stored", '0);
    unlock(1'b0);
    wr(17'h05555, 8'h5A, p);
    expm[21] = 8'h5A;
    wait_to(p + LC + PC);
    rd_at(17'h05555, 0, v); chk("R4 command addr as data", v, 8'h5A);

    // R5: unprotected write and broken sequence
    wr(17'd5, 8'h00, p);
    rd_at(17'd5, p + 1, v); chk("R5 busy starts", v & 8'hBF, 8'h80);
    rd_at(17'd5, p + PC - 1, v); chk("R5 busy length", v & 8'hBF, 8'h80);
    rd_at(17'd5, p + PC, v); chk("R5 nothing stored", v, expm[5]);
    wr(17'h05555, 8'hAA, p);
    wr(17'h02AAA, 8'h12, p);
    rd_at(17'd1, p + 1, v); chk("R5 broken seq busy", v & 8'hBF, 8'h80);
    wait_to(p + PC);
    sweep("R5 broken seq stored nothing", '0);

    // R2: inhibited strobes
    wr2(17'd7, 8'h00, 17'd7, 8'h00, 1'b1, p);
    rd_at(17'd7, p + 1, v); chk("R2 no busy", v, expm[7]);
    unlock(1'b1);
    wr(17'd6, 8'h42, p);
    rd_at(17'd6, p + 1, v); chk("R2 unlock inhibited", v & 8'hBF, 8'h80);
    wait_to(p + PC);
    rd_at(17'd6, 0, v); chk("R2 nothing stored", v, expm[6]);

    // R1: output enable decode
    sel_n = 1'b0; rd_en_n = 1'b0; wstb_n = 1'b0;
    @(negedge clk);
    chk("R1 en with strobe low", {7'b0, dout_en}, 8'h00);
    chk("R1 dout with strobe low", dout, 8'h00);
    sel_n = 1'b1; wstb_n = 1'b1;
    @(negedge clk);
    chk("R1 en deselected", {7'b0, dout_en}, 8'h00);
    rd_en_n = 1'b1;
    @(negedge clk);

    summary();
  end
endmodule